// File: doc/BRIEF.md
# ISA Byte-Lane Register Port Adapter

This block connects an ISA I/O slave port to three internal 16-bit registers: an index pointer, a data window and a configuration window. Host software can reach each register with one 16-bit I/O cycle, or with two 8-bit cycles. The block decodes the port window and stretches the bus cycle with the ready line until the internal register file has answered. It steers bytes between the bus lanes and the register file, and it signals 16-bit capability when that mode is enabled.

In 8-bit mode a read returns one byte on the low lane. An odd address brings the register's upper byte down to bits 7:0. Writes are gathered in pairs. The even byte waits in a holding register. The following odd byte to the same register is placed on top of it, and the two together go out as one 16-bit internal write, so the register never sees a half-updated value. A read, or an access to another register, between the two halves cancels the held byte. An odd write that finds no matching held byte is discarded.

Top module: `isaRegPortAdapter`

## Requirements
- R1: An access is recognised only when `aen` is low, `ioRdN` or `ioWrN` is low, and the address lies in the 8-byte window at `BASE_ADDR` with word offset (addr bits 2:1) of 0 (pointer, `regSel`=0), 1 (data, `regSel`=1) or 2 (config, `regSel`=2). Word offset 3, addresses outside the window, and cycles with `aen` high get no response: the ready line stays high, no internal request is made and no lane is driven.
- R2: `ioChRdy` is low from the first cycle of a recognised access, while the strobe is still settling, until the adapter is ready.
- R3: An internal request holds `regReq`, `regSel` and `regWdata` steady until `regAck`. `ioChRdy` rises in the cycle after the one in which `regAck` is seen.
- R4: `ioCs16N` is low during a recognised access only when `mode16` is high. It stays high in 8-bit mode.
- R5: A 16-bit read drives both lanes (`sdOeLo` and `sdOeHi`) with the full register value.
- R6: An 8-bit read at an even address drives the register's low byte on bits 7:0. `sdOeHi` stays low.
- R7: An 8-bit read at an odd address drives the register's high byte on bits 7:0. `sdOeHi` stays low.
- R8: An 8-bit write at an even address makes no internal write. It only holds the byte, and the cycle is ready without a register handshake.
- R9: An 8-bit odd write that directly follows an even write to the same register makes exactly one internal write, with data {odd byte, even byte}.
- R10: An 8-bit odd write is discarded (no internal write) if it is not directly preceded by an even write to the same register. An intervening read, or a write to another register, cancels the held byte.
- R11: A 16-bit write passes the full bus word to the register in one internal write and bypasses the holding register.
- R12: The bus cycle ends when both strobes are inactive. Within two clocks the data lanes are released, and a new cycle can begin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| aen | input | 1 | Address enable; high marks a DMA cycle, which must be ignored |
| ioRdN | input | 1 | Active-low I/O read strobe |
| ioWrN | input | 1 | Active-low I/O write strobe |
| addr | input | ADDR_W | I/O address |
| sdIn | input | 16 | Bus write data (8-bit cycles use bits 7:0) |
| mode16 | input | 1 | Enables 16-bit I/O cycles |
| sdOut | output | 16 | Bus read data |
| sdOeLo | output | 1 | Drive enable for data bits 7:0 |
| sdOeHi | output | 1 | Drive enable for data bits 15:8 |
| ioChRdy | output | 1 | Channel ready; low inserts wait states |
| ioCs16N | output | 1 | Active-low 16-bit cycle indication |
| regReq | output | 1 | Internal register request |
| regWr | output | 1 | Internal request is a write |
| regSel | output | 2 | Internal register select |
| regWdata | output | 16 | Internal write data |
| regRdata | input | 16 | Internal read data, valid with regAck |
| regAck | input | 1 | Internal request completed |

## Verification
A stale or wrongly cleared holding register does not show up on the cycle that corrupts it. It shows up on the next odd write. That write either makes an internal write it should not make, or misses one it should make, and the bench exposes this by reading the register back through the port straight afterwards. A control state stuck in waiting or holding shows at once as a ready line that never rises, or lanes still driven two clocks after the strobe is released. Wrong lane steering appears in the very read that completes.

// File: rtl/isaRegPkg.sv
package isaRegPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } portState_e;

  typedef struct packed {
    logic capIn;     // latch bus write word
    logic loadHold;  // park even byte
    logic clrHold;   // cancel parked byte
    logic capRead;   // latch steered read data
    logic clrOut;    // drop read data at cycle end
  } dpStrobe_t;

endpackage

// File: rtl/isaPortData.sv
module isaPortData
  import isaRegPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] sdIn,
  input  logic [SEL_W-1:0]  liveSel,
  input  logic              wide,
  input  logic              oddLane,
  input  logic [DATA_W-1:0] regRdata,
  output logic              holdMatch,
  output logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] sdOut
);
  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] inLatch;
  logic [DATA_W-1:0] rdLatch;
  logic [BYTE_W-1:0] holdByte;
  logic [SEL_W-1:0]  holdSel;
  logic              holdValid;
  logic [DATA_W-1:0] steered;

  always_comb begin
    if (wide)         steered = regRdata;
    else if (oddLane) steered = {{BYTE_W{1'b0}}, regRdata[DATA_W-1:BYTE_W]};
    else              steered = {{BYTE_W{1'b0}}, regRdata[BYTE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inLatch   <= '0;
      rdLatch   <= '0;
      holdByte  <= '0;
      holdSel   <= '0;
      holdValid <= 1'b0;
    end else begin
      if (strb.capIn) inLatch <= sdIn;
      if (strb.clrHold) begin
        holdValid <= 1'b0;
      end else if (strb.loadHold) begin
        holdValid <= 1'b1;
        holdSel   <= liveSel;
        holdByte  <= sdIn[BYTE_W-1:0];
      end
      if (strb.clrOut)       rdLatch <= '0;
      else if (strb.capRead) rdLatch <= steered;
    end
  end

  assign holdMatch = holdValid && (holdSel == liveSel);
  assign regWdata  = wide ? inLatch : {inLatch[BYTE_W-1:0], holdByte};
  assign sdOut     = rdLatch;

endmodule

// File: rtl/isaPortCtrl.sv
module isaPortCtrl
  import isaRegPkg::*;
#(
  parameter int              ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300,
  parameter int              WIN_LSB   = 3,
  parameter int              NUM_REGS  = 3,
  parameter int              SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aen,
  input  logic              ioRdN,
  input  logic              ioWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode16,
  input  logic              regAck,
  input  logic              holdMatch,
  output dpStrobe_t         strb,
  output logic [SEL_W-1:0]  liveSel,
  output logic              curWide,
  output logic              curOdd,
  output logic [SEL_W-1:0]  curSel,
  output logic              regReq,
  output logic              regWr,
  output logic              ioChRdy,
  output logic              ioCs16N,
  output logic              sdOeLo,
  output logic              sdOeHi
);
  portState_e state, nextState;
  logic curRd;
  logic rdAct, wrAct, inWin, offOk, hit;

  assign rdAct   = !ioRdN;
  assign wrAct   = !ioWrN;
  assign inWin   = addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB];
  assign liveSel = addr[SEL_W:1];
  assign offOk   = int'(liveSel) < NUM_REGS;
  assign hit     = !aen && (rdAct || wrAct) && inWin && offOk;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: if (hit) begin
        strb.capIn = 1'b1;
        if (rdAct || mode16) begin
          strb.clrHold = 1'b1;
          nextState    = ST_WAIT;
        end else if (!addr[0]) begin
          strb.loadHold = 1'b1;
          nextState     = ST_HOLD;
        end else if (holdMatch) begin
          nextState = ST_WAIT;
        end else begin
          strb.clrHold = 1'b1;
          nextState    = ST_HOLD;
        end
      end
      ST_WAIT: if (regAck) begin
        strb.capRead = curRd;
        strb.clrHold = !curRd && !curWide;
        nextState    = ST_HOLD;
      end
      ST_HOLD: if (!rdAct && !wrAct) begin
        strb.clrOut = 1'b1;
        nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curRd   <= 1'b0;
      curOdd  <= 1'b0;
      curWide <= 1'b0;
      curSel  <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && hit) begin
        curRd   <= rdAct;
        curOdd  <= addr[0];
        curWide <= mode16;
        curSel  <= liveSel;
      end
    end
  end

  assign regReq  = state == ST_WAIT;
  assign regWr   = !curRd;
  assign ioChRdy = (state == ST_HOLD) || (state == ST_IDLE && !hit);
  assign ioCs16N = !(mode16 && hit);
  assign sdOeLo  = (state == ST_HOLD) && curRd;
  assign sdOeHi  = sdOeLo && curWide;

endmodule

// File: rtl/isaRegPortAdapter.sv
module isaRegPortAdapter
  import isaRegPkg::*;
#(
  parameter int                ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aen,
  input  logic              ioRdN,
  input  logic              ioWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       sdIn,
  input  logic              mode16,
  output logic [15:0]       sdOut,
  output logic              sdOeLo,
  output logic              sdOeHi,
  output logic              ioChRdy,
  output logic              ioCs16N,
  output logic              regReq,
  output logic              regWr,
  output logic [1:0]        regSel,
  output logic [15:0]       regWdata,
  input  logic [15:0]       regRdata,
  input  logic              regAck
);
  localparam int DATA_W   = 16;
  localparam int NUM_REGS = 3;
  localparam int SEL_W    = $clog2(NUM_REGS);
  localparam int WIN_LSB  = SEL_W + 1;

  dpStrobe_t        strb;
  logic [SEL_W-1:0] liveSel;
  logic             curWide, curOdd, holdMatch;

  isaPortCtrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WIN_LSB(WIN_LSB),
    .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .aen(aen), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .addr(addr), .mode16(mode16), .regAck(regAck), .holdMatch(holdMatch),
    .strb(strb), .liveSel(liveSel), .curWide(curWide), .curOdd(curOdd),
    .curSel(regSel), .regReq(regReq), .regWr(regWr), .ioChRdy(ioChRdy),
    .ioCs16N(ioCs16N), .sdOeLo(sdOeLo), .sdOeHi(sdOeHi)
  );

  isaPortData #(.DATA_W(DATA_W), .SEL_W(SEL_W)) data (
    .clk(clk), .rstN(rstN), .strb(strb), .sdIn(sdIn), .liveSel(liveSel),
    .wide(curWide), .oddLane(curOdd), .regRdata(regRdata),
    .holdMatch(holdMatch), .regWdata(regWdata), .sdOut(sdOut)
  );

endmodule

// File: rtl/isaRegPortChecker.sv
module isaRegPortChecker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              aen,
  input logic              ioRdN,
  input logic              ioWrN,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       sdIn,
  input logic              mode16,
  input logic [15:0]       sdOut,
  input logic              sdOeLo,
  input logic              sdOeHi,
  input logic              ioChRdy,
  input logic              ioCs16N,
  input logic              regReq,
  input logic              regWr,
  input logic [1:0]        regSel,
  input logic [15:0]       regWdata,
  input logic [15:0]       regRdata,
  input logic              regAck
);
  // R2: while the register file is busy the bus must be stalled
  assert_wait_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    regReq |-> !ioChRdy);

  // R3: request persists until acknowledged
  assert_req_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> regReq);

  // R3: select and write word do not move while waiting
  assert_req_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> ($stable(regWdata) && $stable(regSel)));

  // R3: ready rises the cycle after the acknowledge
  assert_rdy_after_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regAck) |=> ioChRdy);

  // R6: upper lane only in 16-bit mode
  assert_hi_lane_R6: assert property (@(posedge clk) disable iff (!rstN)
    sdOeHi |-> (sdOeLo && mode16));

  // R12: lanes released once strobes have been idle a full cycle
  assert_release_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdN && ioWrN && $past(ioRdN && ioWrN)) |-> !sdOeLo);

  // R1: no request is raised from a DMA-marked cycle start
  assert_aen_ignored_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!regReq && aen) |=> !regReq);

endmodule

bind isaRegPortAdapter isaRegPortChecker #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/tb_isaRegPortAdapter.sv
module tb_isaRegPortAdapter;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] BASE = 10'h300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aen = 1'b1, ioRdN = 1'b1, ioWrN = 1'b1, mode16 = 1'b0;
  logic [9:0]  addr = '0;
  logic [15:0] sdIn = '0;
  logic [15:0] sdOut, regWdata, regRdata;
  logic sdOeLo, sdOeHi, ioChRdy, ioCs16N, regReq, regWr, regAck;
  logic [1:0] regSel;

  logic [15:0] model [0:3];
  logic [1:0]  ackCnt;
  int wrCount;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isaRegPortAdapter #(.ADDR_W(10), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rstN(rstN), .aen(aen), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .addr(addr), .sdIn(sdIn), .mode16(mode16), .sdOut(sdOut),
    .sdOeLo(sdOeLo), .sdOeHi(sdOeHi), .ioChRdy(ioChRdy), .ioCs16N(ioCs16N),
    .regReq(regReq), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .regAck(regAck)
  );

  // register file stand-in: acknowledges three cycles into a request
  assign regRdata = model[regSel];
  always @(posedge clk) begin
    if (!rstN) begin
      regAck   <= 1'b0;
      ackCnt   <= '0;
      wrCount  <= 0;
      model[0] <= 16'hA1B2;
      model[1] <= 16'hC3D4;
      model[2] <= 16'hE5F6;
      model[3] <= 16'h0000;
    end else begin
      regAck <= 1'b0;
      if (regReq && !regAck) begin
        if (ackCnt == 2'd2) begin
          regAck <= 1'b1;
          ackCnt <= '0;
          if (regWr) begin
            model[regSel] <= regWdata;
            wrCount <= wrCount + 1;
          end
        end else begin
          ackCnt <= ackCnt + 1'b1;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one complete I/O cycle; results sampled at falling edges
  task automatic busCycle(input bit isRd, input logic [9:0] a, input logic [15:0] d,
                          output logic [15:0] q, output bit oeLo, output bit oeHi,
                          output bit cs16Seen, output bit rdyLowStart, output int waitCnt);
    @(negedge clk);
    aen = 1'b0; addr = a; sdIn = d;
    if (isRd) ioRdN = 1'b0; else ioWrN = 1'b0;
    #1;
    rdyLowStart = !ioChRdy;
    cs16Seen    = !ioCs16N;
    waitCnt     = 0;
    @(negedge clk);
    while (!ioChRdy && waitCnt < 40) begin
      waitCnt++;
      if (!ioCs16N) cs16Seen = 1'b1;
      @(negedge clk);
    end
    if (!ioCs16N) cs16Seen = 1'b1;
    q = sdOut; oeLo = sdOeLo; oeHi = sdOeHi;
    ioRdN = 1'b1; ioWrN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R12 lanes released after strobe", {30'd0, sdOeLo, sdOeHi}, 32'd0);
    check("R12 ready idle after cycle", {31'd0, ioChRdy}, 32'd1);
    aen = 1'b1;
  endtask

  logic [15:0] q;
  bit oeLo, oeHi, cs16, rdyLow;
  int waitCnt, wBefore;

  task automatic testReset();
    check("reset ioChRdy", {31'd0, ioChRdy}, 32'd1);
    check("reset ioCs16N", {31'd0, ioCs16N}, 32'd1);
    check("reset lanes", {30'd0, sdOeLo, sdOeHi}, 32'd0);
    check("reset regReq", {31'd0, regReq}, 32'd0);
  endtask

  task automatic test16Read();
    mode16 = 1'b1;
    busCycle(1, BASE + 10'd2, 16'h0, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R5 16-bit read data", {16'd0, q}, 32'hC3D4);
    check("R5 both lanes driven", {30'd0, oeLo, oeHi}, 32'd3);
    check("R4 cs16 low in 16-bit mode", {31'd0, cs16}, 32'd1);
    check("R2 ready low at start", {31'd0, rdyLow}, 32'd1);
    check("R3 wait states until ack", waitCnt, 32'd4);
    mode16 = 1'b0;
  endtask

  task automatic test8Reads();
    busCycle(1, BASE + 10'd4, 16'h0, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R6 even byte on low lane", {16'd0, q}, 32'h00F6);
    check("R6 only low lane driven", {30'd0, oeLo, oeHi}, 32'd2);
    check("R4 cs16 high in 8-bit mode", {31'd0, cs16}, 32'd0);
    busCycle(1, BASE + 10'd5, 16'h0, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R7 odd byte swapped down", {16'd0, q}, 32'h00E5);
    check("R7 only low lane driven", {30'd0, oeLo, oeHi}, 32'd2);
  endtask

  task automatic testPairWrite();
    wBefore = wrCount;
    busCycle(0, BASE + 10'd2, 16'h0011, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R8 even write makes no internal write", wrCount, wBefore);
    check("R8 even write needs no handshake", waitCnt, 32'd0);
    check("R2 even write stalls at start", {31'd0, rdyLow}, 32'd1);
    busCycle(0, BASE + 10'd3, 16'h0022, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R9 single merged write", wrCount, wBefore + 1);
    busCycle(1, BASE + 10'd3, 16'h0, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R9 merged high byte", {16'd0, q}, 32'h0022);
    busCycle(1, BASE + 10'd2, 16'h0, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R9 merged low byte", {16'd0, q}, 32'h0011);
  endtask

  task automatic testOrphanOdd();
    wBefore = wrCount;
    busCycle(0, BASE + 10'd0, 16'h0033, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    busCycle(1, BASE + 10'd4, 16'h0, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    busCycle(0, BASE + 10'd1, 16'h0044, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R10 odd write after read dropped", wrCount, wBefore);
    busCycle(0, BASE + 10'd0, 16'h0055, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    busCycle(0, BASE + 10'd3, 16'h0066, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R10 odd write to other register dropped", wrCount, wBefore);
    busCycle(0, BASE + 10'd1, 16'h0077, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R10 held byte cancelled by other register", wrCount, wBefore);
    busCycle(1, BASE + 10'd1, 16'h0, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R10 pointer high byte untouched", {16'd0, q}, 32'h00A1);
    busCycle(1, BASE + 10'd3, 16'h0, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R10 data high byte untouched", {16'd0, q}, 32'h0022);
  endtask

  task automatic test16Write();
    mode16 = 1'b1;
    wBefore = wrCount;
    busCycle(0, BASE + 10'd4, 16'hBEEF, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R11 one direct write", wrCount, wBefore + 1);
    check("R11 write waits for ack", waitCnt, 32'd4);
    busCycle(1, BASE + 10'd4, 16'h0, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R11 full word stored", {16'd0, q}, 32'hBEEF);
    mode16 = 1'b0;
  endtask

  task automatic testDecode();
    wBefore = wrCount;
    mode16 = 1'b1;
    busCycle(0, BASE + 10'd6, 16'h1111, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R1 unmapped offset no stall", {31'd0, rdyLow}, 32'd0);
    check("R1 unmapped offset no cs16", {31'd0, cs16}, 32'd0);
    busCycle(1, 10'h202, 16'h0, q, oeLo, oeHi, cs16, rdyLow, waitCnt);
    check("R1 outside window not driven", {30'd0, oeLo, oeHi}, 32'd0);
    check("R1 outside window no stall", {31'd0, rdyLow}, 32'd0);
    // DMA-marked cycle: aen kept high
    @(negedge clk);
    addr = BASE + 10'd2; ioWrN = 1'b0; sdIn = 16'h2222;
    #1;
    check("R1 aen high no stall", {31'd0, ioChRdy}, 32'd1);
    repeat (6) @(negedge clk);
    check("R1 aen high no lanes", {30'd0, sdOeLo, sdOeHi}, 32'd0);
    ioWrN = 1'b1;
    @(negedge clk);
    check("R1 no internal write", wrCount, wBefore);
    mode16 = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    test16Read();
    test8Reads();
    testPairWrite();
    testOrphanOdd();
    test16Write();
    testDecode();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule